// File: doc/BRIEF.md
# Configurable Ethernet Test Frame Source

This block generates Ethernet test frames on a byte-lane streaming output with valid/ready flow control, start and end markers and an empty-byte count on the last beat. Each frame starts with a destination MAC address, then a source MAC address, then a 16-bit length/type field, then a counting payload. Frame check sequence insertion is left to the MAC downstream.

A small synchronous register port programs the block. Registers set the run enable, the length mode (fixed, random or a rising sweep between two bounds), the length bounds, an optional frame limit that stops the run by itself, back-to-back or randomly gapped spacing, and both MAC addresses. Two transmit counters record the frames and the bytes sent. An input marks the datapath as looped back at the MAC. While it is set the block starts no frame, and software can see it in the control register.

Top module: `eth_testgen`

## Requirements
- R1: Register offsets are 0 control, 1 size, 2 frame limit, 3 destination low 32 bits, 4 destination high 16 bits, 5 source low 32 bits, 6 source high 16 bits, 7 frame counter, 8 byte counter. After reset they read 0x10, 0x25800040, 10, 0x56780ADD, 0x1234, 0x43210ADD and 0x8765, and tx_valid is low.
- R2: A frame of L bytes carries destination bytes (most significant first), then source bytes, then L-14 as a 16-bit big-endian field, then payload byte i equal to i mod 256. Beat lane 0 (the first byte) is tx_data[63:56].
- R3: A frame of L bytes takes ceil(L/8) beats. tx_empty gives the unused byte count on the end beat and is 0 on every other beat.
- R4: Control bits [5:4] select the length mode. Code 01 (fixed) and code 11 both send size bits [13:0] as the length.
- R5: Code 10 (sweep) starts at the lower bound (size bits [13:0]) and adds one byte per frame. After a frame at the upper bound (size bits [29:16]) it returns to the lower bound. It restarts at the lower bound each time the enable is set.
- R6: Code 00 (random) gives each frame a pseudo-random length within 64 to 9600 bytes.
- R7: When control bit 6 is set, exactly the frame limit of frames is sent and the output then stays idle. Setting the enable bit (bit 1) again after clearing it starts a fresh count.
- R8: When control bit 7 is set and the run goes on, the start beat of the next frame follows the end beat in the next cycle.
- R9: When control bit 7 is clear, 0 to 15 idle cycles separate consecutive frames.
- R10: Clearing the enable never shortens a frame. The frame in progress ends with its end beat, and then no further frame starts.
- R11: Control bit 3 reads the loopback input. While loopback is high no frame starts.
- R12: While tx_valid is high and tx_ready low, every output holds its value.
- R13: The frame counter counts every completed frame and the byte counter adds up their lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| loopback | input | 1 | Datapath is looped back at the MAC |
| tx_ready | input | 1 | Downstream accepts the current beat |
| tx_valid | output | 1 | Beat present |
| tx_sop | output | 1 | First beat of a frame |
| tx_eop | output | 1 | Last beat of a frame |
| tx_empty | output | 3 | Unused bytes on the last beat |
| tx_data | output | 64 | Frame bytes, first byte in the top lane |

## Verification
A scoreboard compares each frame with a byte model for several input patterns. Back-to-back minimum-size frames test the spacing of the end and start beats. A fixed length of 70 under the spare mode code, with new addresses, tests a partial last beat and the header field. A sweep from 60 to 62 under random backpressure tests the wrap order and that outputs hold while stalled. Gapped runs test the gap bound and random runs test the length bound. The remaining runs cover disabling in the middle of a frame, loopback blocking, restarting the frame limit and the counter totals, each of which shows a different way a run can end.

// File: rtl/eth_tg_pkg.sv
`timescale 1ns/1ps
package eth_tg_pkg;

   localparam int HDR_BYTES = 14;
   localparam int RAND_MIN  = 64;
   localparam int RAND_MAX  = 9600;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_SEND = 2'd2
   } tg_state_e;

   typedef enum logic [1:0] {
      LM_RANDOM = 2'b00,
      LM_FIXED  = 2'b01,
      LM_SWEEP  = 2'b10,
      LM_SPARE  = 2'b11
   } len_mode_e;

   typedef struct packed {
      logic      nogap;
      logic      stop_at_limit;
      len_mode_e mode;
      logic      run;
   } tg_ctrl_t;

   // Byte at frame offset pos, zero past the frame end.
   function automatic logic [7:0] frame_byte(input logic [15:0] pos,
                                             input logic [47:0] dst,
                                             input logic [47:0] src,
                                             input logic [15:0] len);
      logic [15:0] tl;
      int p;
      tl = len - 16'(HDR_BYTES);
      p  = int'(pos);
      if (pos >= len)  return 8'h00;
      else if (p < 6)  return dst[47-8*p -: 8];
      else if (p < 12) return src[47-8*(p-6) -: 8];
      else if (p == 12) return tl[15:8];
      else if (p == 13) return tl[7:0];
      else return 8'(p - HDR_BYTES);
   endfunction

endpackage

// File: rtl/eth_tg_lfsr.sv
`timescale 1ns/1ps
module eth_tg_lfsr #(
   parameter int             W     = 16,
   parameter logic [W-1:0]   TAPS  = 16'hB400,
   parameter logic [W-1:0]   SEED  = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] q
);

   generate
      if (W < 8) begin : g_bad_width
         $error("eth_tg_lfsr: W must be at least 8");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("eth_tg_lfsr: SEED must be non-zero");
      end
   endgenerate

   logic [W-1:0] q_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      q_q <= SEED;
      else if (q_q[0]) q_q <= (q_q >> 1) ^ TAPS;
      else             q_q <= q_q >> 1;
   end

   assign q = q_q;

   a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      q_q != '0);

endmodule

// File: rtl/eth_tg_len_sel.sv
`timescale 1ns/1ps
module eth_tg_len_sel
   import eth_tg_pkg::*;
#(
   parameter int LEN_W  = 14,
   parameter int RAND_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  len_mode_e         mode,
   input  logic [LEN_W-1:0]  lo,
   input  logic [LEN_W-1:0]  hi,
   input  logic [RAND_W-1:0] rnd,
   input  logic              restart,
   input  logic              take,
   output logic [LEN_W-1:0]  len
);

   localparam logic [LEN_W-1:0] HDR_L  = LEN_W'(HDR_BYTES);
   localparam logic [LEN_W-1:0] RMIN_L = LEN_W'(RAND_MIN);
   localparam logic [LEN_W-1:0] RMAX_L = LEN_W'(RAND_MAX);

   generate
      if (RAND_W < LEN_W) begin : g_bad_rand
         $error("eth_tg_len_sel: RAND_W must cover LEN_W");
      end
   endgenerate

   logic [LEN_W-1:0] sweep_q;
   logic [LEN_W-1:0] lo_f, hi_f, sweep_cur, rnd_raw, rnd_len;

   always_comb begin
      lo_f      = (lo < HDR_L) ? HDR_L : lo;
      hi_f      = (hi < lo_f) ? lo_f : hi;
      sweep_cur = (restart || sweep_q < lo_f || sweep_q > hi_f) ? lo_f : sweep_q;
      rnd_raw   = rnd[LEN_W-1:0];
      if (rnd_raw < RMIN_L)      rnd_len = RMIN_L;
      else if (rnd_raw > RMAX_L) rnd_len = RMAX_L;
      else                       rnd_len = rnd_raw;
      case (mode)
         LM_RANDOM: len = rnd_len;
         LM_SWEEP:  len = sweep_cur;
         default:   len = lo_f;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         sweep_q <= HDR_L;
      else if (take && mode == LM_SWEEP)
         sweep_q <= (sweep_cur >= hi_f) ? lo_f : sweep_cur + 1'b1;
      else if (restart)
         sweep_q <= lo_f;
   end

   a_r5_sweep_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mode == LM_SWEEP) |-> (len >= lo_f && len <= hi_f));

endmodule

// File: rtl/eth_tg_beat.sv
`timescale 1ns/1ps
module eth_tg_beat
   import eth_tg_pkg::*;
#(
   parameter int DB     = 8,
   parameter int LEN_W  = 14,
   parameter int BEAT_W = 14
) (
   input  logic [BEAT_W-1:0] beat,
   input  logic [LEN_W-1:0]  len,
   input  logic [47:0]       dst,
   input  logic [47:0]       src,
   output logic [DB*8-1:0]   data
);

   generate
      for (genvar l = 0; l < DB; l++) begin : g_lane
         logic [15:0] pos;
         assign pos = 16'(beat) * 16'(DB) + 16'(l);
         assign data[(DB-1-l)*8 +: 8] = frame_byte(pos, dst, src, 16'(len));
      end
   endgenerate

endmodule

// File: rtl/eth_tg_ctrl.sv
`timescale 1ns/1ps
module eth_tg_ctrl
   import eth_tg_pkg::*;
#(
   parameter int DB     = 8,
   parameter int LEN_W  = 14,
   parameter int CNT_W  = 32,
   parameter int GAP_W  = 4,
   localparam int EW     = $clog2(DB),
   localparam int BEAT_W = LEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              loop,
   input  logic              stop_mode,
   input  logic              nogap,
   input  logic [CNT_W-1:0]  limit,
   input  logic [LEN_W-1:0]  next_len,
   input  logic [GAP_W-1:0]  rnd_gap,
   input  logic              out_ready,
   output logic              valid,
   output logic              sop,
   output logic              eop,
   output logic [EW-1:0]     empty,
   output logic [LEN_W-1:0]  len,
   output logic [BEAT_W-1:0] beat,
   output logic              take,
   output logic              restart,
   output logic              frame_done
);

   localparam int IDLE_W = GAP_W + 2;
   localparam logic [GAP_W-1:0] GAP_MAX = '1;

   tg_state_e         state_q;
   logic [BEAT_W-1:0] beat_q;
   logic [LEN_W-1:0]  len_q;
   logic [CNT_W-1:0]  sent_q, eff_sent, sent_inc;
   logic [GAP_W-1:0]  gap_q;
   logic [IDLE_W-1:0] idle_q;
   logic              en_q;
   logic              en_rise, go, ok_idle, ok_next, last, fire, done, want_gap;
   logic [EW-1:0]     pad;

   always_comb begin
      en_rise  = en & ~en_q;
      eff_sent = en_rise ? '0 : sent_q;
      sent_inc = eff_sent + 1'b1;
      go       = en & ~loop;
      ok_idle  = go & ~(stop_mode & (eff_sent >= limit));
      ok_next  = go & ~(stop_mode & (sent_inc >= limit));
      last     = (beat_q == BEAT_W'((len_q - 1'b1) >> EW));
      fire     = (state_q == ST_SEND) & out_ready;
      done     = fire & last;
      want_gap = ~nogap & (rnd_gap != '0);
      take     = ((state_q == ST_IDLE) & ok_idle)
               | ((state_q == ST_GAP) & (gap_q == GAP_W'(1)) & ok_idle)
               | (done & ok_next & ~want_gap);
      pad      = '0 - len_q[EW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         len_q   <= LEN_W'(HDR_BYTES);
         sent_q  <= '0;
         gap_q   <= '0;
         idle_q  <= '0;
         en_q    <= 1'b0;
      end else begin
         en_q <= en;
         if (state_q == ST_SEND)     idle_q <= '0;
         else if (idle_q != '1)      idle_q <= idle_q + 1'b1;
         if (en_rise) sent_q <= '0;
         if (done)    sent_q <= sent_inc;
         if (take) begin
            state_q <= ST_SEND;
            beat_q  <= '0;
            len_q   <= next_len;
         end else begin
            case (state_q)
               ST_GAP: begin
                  if (gap_q == GAP_W'(1)) state_q <= ST_IDLE;
                  else                    gap_q   <= gap_q - 1'b1;
               end
               ST_SEND: begin
                  if (done) begin
                     if (want_gap && ok_next) begin
                        state_q <= ST_GAP;
                        gap_q   <= rnd_gap;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else if (fire) begin
                     beat_q <= beat_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign valid      = (state_q == ST_SEND);
   assign sop        = valid & (beat_q == '0);
   assign eop        = valid & last;
   assign empty      = eop ? pad : '0;
   assign len        = len_q;
   assign beat       = beat_q;
   assign restart    = en_rise;
   assign frame_done = done;

   a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && eop && out_ready && nogap && en && !loop && !stop_mode) |=> (valid && sop));

   a_r9_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sop && $past(state_q == ST_GAP)) |-> (idle_q <= IDLE_W'(GAP_MAX)));

   a_r10_frame_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !eop) |=> valid);

   a_r11_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (loop && !valid) |=> !valid);

endmodule

// File: rtl/eth_testgen.sv
`timescale 1ns/1ps
module eth_testgen
   import eth_tg_pkg::*;
#(
   parameter int                DATA_BYTES  = 8,
   parameter int                LEN_W       = 14,
   parameter int                CNT_W       = 32,
   parameter int                GAP_W       = 4,
   parameter int                LFSR_W      = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS   = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED   = 16'hACE1,
   parameter logic [47:0]       DST_INIT    = 48'h1234_5678_0ADD,
   parameter logic [47:0]       SRC_INIT    = 48'h8765_4321_0ADD,
   parameter int                LEN_LO_INIT = 64,
   parameter int                LEN_HI_INIT = 9600,
   parameter int                LIMIT_INIT  = 10,
   localparam int               EW          = $clog2(DATA_BYTES),
   localparam int               DW          = DATA_BYTES * 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [3:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   input  logic          loopback,
   input  logic          tx_ready,
   output logic          tx_valid,
   output logic          tx_sop,
   output logic          tx_eop,
   output logic [EW-1:0] tx_empty,
   output logic [DW-1:0] tx_data
);

   localparam int BEAT_W = LEN_W;

   generate
      if (DATA_BYTES < 4 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_db
         $error("eth_testgen: DATA_BYTES must be a power of two, at least 4");
      end
      if (LEN_W < 14 || LEN_W > 16) begin : g_bad_len
         $error("eth_testgen: LEN_W must be 14 to 16");
      end
      if (CNT_W > 32) begin : g_bad_cnt
         $error("eth_testgen: CNT_W must fit the 32-bit register port");
      end
      if (LFSR_W < LEN_W || LFSR_W < GAP_W) begin : g_bad_lfsr
         $error("eth_testgen: LFSR_W too narrow");
      end
   endgenerate

   // register file
   tg_ctrl_t         ctrl_q;
   logic [LEN_W-1:0] lo_q, hi_q;
   logic [CNT_W-1:0] limit_q, frames_q, bytes_q;
   logic [47:0]      dst_q, src_q;

   // datapath links
   logic [LFSR_W-1:0] rnd;
   logic [LEN_W-1:0]  next_len, cur_len;
   logic [BEAT_W-1:0] beat;
   logic              take, restart, frame_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '{nogap: 1'b0, stop_at_limit: 1'b0, mode: LM_FIXED, run: 1'b0};
         lo_q    <= LEN_W'(LEN_LO_INIT);
         hi_q    <= LEN_W'(LEN_HI_INIT);
         limit_q <= CNT_W'(LIMIT_INIT);
         dst_q   <= DST_INIT;
         src_q   <= SRC_INIT;
      end else if (cfg_we) begin
         case (cfg_addr)
            4'd0: ctrl_q <= '{nogap: cfg_wdata[7], stop_at_limit: cfg_wdata[6],
                              mode: len_mode_e'(cfg_wdata[5:4]), run: cfg_wdata[1]};
            4'd1: begin
               lo_q <= LEN_W'(cfg_wdata[13:0]);
               hi_q <= LEN_W'(cfg_wdata[29:16]);
            end
            4'd2: limit_q       <= CNT_W'(cfg_wdata);
            4'd3: dst_q[31:0]   <= cfg_wdata;
            4'd4: dst_q[47:32]  <= cfg_wdata[15:0];
            4'd5: src_q[31:0]   <= cfg_wdata;
            4'd6: src_q[47:32]  <= cfg_wdata[15:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frames_q <= '0;
         bytes_q  <= '0;
      end else if (frame_done) begin
         frames_q <= frames_q + 1'b1;
         bytes_q  <= bytes_q + CNT_W'(cur_len);
      end
   end

   always_comb begin
      case (cfg_addr)
         4'd0: cfg_rdata = {24'd0, ctrl_q.nogap, ctrl_q.stop_at_limit, ctrl_q.mode,
                            loopback, 1'b0, ctrl_q.run, 1'b0};
         4'd1: cfg_rdata = {2'b00, 14'(hi_q), 2'b00, 14'(lo_q)};
         4'd2: cfg_rdata = 32'(limit_q);
         4'd3: cfg_rdata = dst_q[31:0];
         4'd4: cfg_rdata = {16'd0, dst_q[47:32]};
         4'd5: cfg_rdata = src_q[31:0];
         4'd6: cfg_rdata = {16'd0, src_q[47:32]};
         4'd7: cfg_rdata = 32'(frames_q);
         4'd8: cfg_rdata = 32'(bytes_q);
         default: cfg_rdata = 32'd0;
      endcase
   end

   eth_tg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (rnd)
   );

   eth_tg_len_sel #(.LEN_W(LEN_W), .RAND_W(LFSR_W)) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (ctrl_q.mode),
      .lo      (lo_q),
      .hi      (hi_q),
      .rnd     (rnd),
      .restart (restart),
      .take    (take),
      .len     (next_len)
   );

   eth_tg_ctrl #(.DB(DATA_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl_q.run),
      .loop       (loopback),
      .stop_mode  (ctrl_q.stop_at_limit),
      .nogap      (ctrl_q.nogap),
      .limit      (limit_q),
      .next_len   (next_len),
      .rnd_gap    (rnd[LFSR_W-1 -: GAP_W]),
      .out_ready  (tx_ready),
      .valid      (tx_valid),
      .sop        (tx_sop),
      .eop        (tx_eop),
      .empty      (tx_empty),
      .len        (cur_len),
      .beat       (beat),
      .take       (take),
      .restart    (restart),
      .frame_done (frame_done)
   );

   eth_tg_beat #(.DB(DATA_BYTES), .LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_beat (
      .beat (beat),
      .len  (cur_len),
      .dst  (dst_q),
      .src  (src_q),
      .data (tx_data)
   );

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
                                   && $stable(tx_eop) && $stable(tx_empty)));

   a_r6_random_range: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ctrl_q.mode == LM_RANDOM)
         |=> (cur_len >= LEN_W'(RAND_MIN) && cur_len <= LEN_W'(RAND_MAX)));

   a_r13_frame_count: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_eop && tx_ready) |=> (frames_q == $past(frames_q) + 1'b1));

endmodule

// File: tb/eth_testgen_tb.sv
`timescale 1ns/1ps
module eth_testgen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [3:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata;
   logic        loopback;
   logic        tx_ready;
   logic        tx_valid, tx_sop, tx_eop;
   logic [2:0]  tx_empty;
   logic [63:0] tx_data;

   always #2.5 clk = ~clk;

   eth_testgen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .loopback  (loopback),
      .tx_ready  (tx_ready),
      .tx_valid  (tx_valid),
      .tx_sop    (tx_sop),
      .tx_eop    (tx_eop),
      .tx_empty  (tx_empty),
      .tx_data   (tx_data)
   );

   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;
   int          exp_q[$];
   string       tag_q[$];
   string       body_tag = "R2";
   bit          bp_on = 1'b0;
   bit          want_b2b = 1'b0;
   bit          want_gapmax = 1'b0;
   bit          first_in_burst = 1'b1;
   logic [47:0] m_dst = 48'h1234_5678_0ADD;
   logic [47:0] m_src = 48'h8765_4321_0ADD;
   longint      cyc = 0;
   longint      eop_cyc = 0;
   bit          in_frame = 1'b0;
   logic [7:0]  fbuf[$];
   int          frames_seen = 0;
   longint      bytes_seen = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input int i, input int l);
      logic [15:0] tl;
      tl = 16'(l - 14);
      if (i < 6)       return m_dst[47-8*i -: 8];
      else if (i < 12) return m_src[47-8*(i-6) -: 8];
      else if (i == 12) return tl[15:8];
      else if (i == 13) return tl[7:0];
      else return 8'(i - 14);
   endfunction

   task automatic check_frame();
      int    l, e, bad;
      string t;
      l = fbuf.size();
      frames_seen++;
      bytes_seen += l;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R7 unexpected frame", l, 0);
         return;
      end
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e == 0) chk(l >= 64 && l <= 9600, t, l, 9600);
      else        chk(l == e, t, l, e);
      bad = 0;
      for (int i = 0; i < l; i++) if (fbuf[i] !== mb(i, l)) bad++;
      chk(bad == 0, body_tag, bad, 0);
   endtask

   // scoreboard monitor: drive ready, then capture beats that handshake
   always @(negedge clk) begin
      cyc++;
      tx_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (rst_n === 1'b1 && tx_valid && tx_ready) begin
         if (tx_sop) begin
            if (in_frame) chk(1'b0, "R3 start inside frame", 1, 0);
            fbuf.delete();
            in_frame = 1'b1;
            if (!first_in_burst) begin
               if (want_b2b)    chk(cyc - eop_cyc - 1 == 0, "R8", cyc - eop_cyc - 1, 0);
               if (want_gapmax) chk(cyc - eop_cyc - 1 <= 15, "R9", cyc - eop_cyc - 1, 15);
            end
            first_in_burst = 1'b0;
         end
         if (!tx_eop && tx_empty != 3'd0) chk(1'b0, "R3 empty mid-frame", tx_empty, 0);
         for (int k = 0; k < (tx_eop ? 8 - int'(tx_empty) : 8); k++)
            fbuf.push_back(tx_data[63-8*k -: 8]);
         if (tx_eop) begin
            eop_cyc  = cyc;
            in_frame = 1'b0;
            check_frame();
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic push(input int n, input int l, input string t);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(l);
         tag_q.push_back(t);
      end
   endtask

   task automatic drain(input string t);
      int w;
      w = 0;
      while ((exp_q.size() != 0 || in_frame) && w < 40000) begin
         @(negedge clk);
         w++;
      end
      chk(exp_q.size() == 0, t, exp_q.size(), 0);
   endtask

   task automatic quiet(input int n, input string t);
      int v;
      v = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tx_valid) v++;
      end
      chk(v == 0, t, v, 0);
   endtask

   logic [31:0] r;
   int          base;

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 4'd0; cfg_wdata = 32'd0; loopback = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(tx_valid == 1'b0, "R1 valid", tx_valid, 0);
      rd(4'd0, r); chk(r == 32'h10, "R1 control", r, 32'h10);
      rd(4'd1, r); chk(r == 32'h25800040, "R1 size", r, 32'h25800040);
      rd(4'd2, r); chk(r == 32'd10, "R1 limit", r, 10);
      rd(4'd3, r); chk(r == 32'h56780ADD, "R1 dst low", r, 32'h56780ADD);
      rd(4'd4, r); chk(r == 32'h1234, "R1 dst high", r, 32'h1234);
      rd(4'd5, r); chk(r == 32'h43210ADD, "R1 src low", r, 32'h43210ADD);
      rd(4'd6, r); chk(r == 32'h8765, "R1 src high", r, 32'h8765);

      // R7/R8: three back-to-back 64-byte frames, then stop
      wr(4'd2, 32'd3);
      want_b2b = 1'b1; first_in_burst = 1'b1;
      push(3, 64, "R4");
      base = frames_seen;
      wr(4'd0, 32'hD2);
      drain("R7 limit reached");
      quiet(40, "R7 idle after limit");
      chk(frames_seen - base == 3, "R7 count", frames_seen - base, 3);

      // R7 restart on a new enable
      wr(4'd0, 32'hD0);
      push(3, 64, "R4");
      first_in_burst = 1'b1;
      base = frames_seen;
      wr(4'd0, 32'hD2);
      drain("R7 restart");
      quiet(30, "R7 idle after restart");
      chk(frames_seen - base == 3, "R7 restart count", frames_seen - base, 3);

      // R4 spare code, 70 bytes (R3 partial beat), new addresses (R2)
      wr(4'd0, 32'h0);
      wr(4'd3, 32'hA1B2C3D4); wr(4'd4, 32'h0000E5F6);
      wr(4'd5, 32'h01020304); wr(4'd6, 32'h00000506);
      m_dst = 48'hE5F6_A1B2_C3D4; m_src = 48'h0506_0102_0304;
      wr(4'd1, 32'h25800046);
      wr(4'd2, 32'd2);
      push(2, 70, "R3");
      first_in_burst = 1'b1;
      wr(4'd0, 32'hF2);
      drain("R4 spare code");
      quiet(20, "R7 idle");

      // R5 sweep 60..62 with backpressure (R12)
      wr(4'd0, 32'h0);
      want_b2b = 1'b0;
      wr(4'd1, 32'h003E003C);
      wr(4'd2, 32'd5);
      push(1, 60, "R5"); push(1, 61, "R5"); push(1, 62, "R5");
      push(1, 60, "R5 wrap"); push(1, 61, "R5");
      bp_on = 1'b1; body_tag = "R12";
      wr(4'd0, 32'hE2);
      drain("R5 sweep");
      quiet(20, "R7 idle");
      bp_on = 1'b0; body_tag = "R2";

      // R9 gapped fixed 64
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h25800040);
      wr(4'd2, 32'd6);
      push(6, 64, "R4");
      want_gapmax = 1'b1; first_in_burst = 1'b1;
      wr(4'd0, 32'h52);
      drain("R9 gapped run");
      quiet(30, "R7 idle");
      want_gapmax = 1'b0;

      // R6 random lengths
      wr(4'd0, 32'h0);
      wr(4'd2, 32'd3);
      push(3, 0, "R6");
      wr(4'd0, 32'hC2);
      drain("R6 random run");
      quiet(20, "R7 idle");

      // R10 disable in the middle of a frame
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h258000C8);
      push(1, 200, "R10");
      wr(4'd0, 32'h92);
      while (!tx_valid) @(negedge clk);
      repeat (3) @(negedge clk);
      wr(4'd0, 32'h90);
      drain("R10 frame completed");
      quiet(40, "R10 no new frame");

      // R11 loopback
      loopback = 1'b1;
      base = frames_seen;
      wr(4'd0, 32'h92);
      rd(4'd0, r); chk(r == 32'h9A, "R11 status bit", r, 32'h9A);
      quiet(60, "R11 no frames");
      wr(4'd0, 32'h90);
      loopback = 1'b0;
      chk(frames_seen == base, "R11 frame count", frames_seen - base, 0);

      // R13 counters
      rd(4'd7, r); chk(r == 32'd23, "R13 frame counter", r, 23);
      rd(4'd8, r); chk(r == 32'(bytes_seen), "R13 byte counter", r, bytes_seen);

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule